// File: doc/BRIEF.md
# Bus Chip-Select Decoder

This block turns the address and strobe lines of an 8-bit processor bus into per-device read and write enables. The bus carries a 16-bit address and four active-low strobes: memory read, memory write, I/O read and I/O write. Which strobe is low decides which address space the access belongs to.

Memory devices are matched on all 16 address lines. I/O ports live in a separate 256-entry space and are matched on an 8-bit port number. That port number is taken from either the upper or the lower byte of the address, because the bus repeats it on both bytes.

Each port has two elaboration-time values: a base address and a care mask. A set mask bit means the line is compared. A fully set mask gives absolute decoding, where the port has exactly one address. Clearing mask bits gives partial decoding, where the port answers at every address that agrees on the compared lines.

The enables are registered, so each one is glitch-free and follows the bus by one clock.

Top module: `bus_select_decoder`

## Requirements
- R1: While `rst_n` is low, every select output is 0. This holds whatever the address and strobes are.
- R2: A memory port whose care mask is all ones asserts its select for exactly one 16-bit address, the one equal to its base. Base 0x2000 with mask 0xFFFF hits at 0x2000 and misses at 0x2001.
- R3: Address lines whose care-mask bit is 0 are ignored. With base 0x8000 and mask 0xF000, the port answers anywhere in 0x8000..0x8FFF and misses at 0x9000. This applies to I/O ports as well.
- R4: I/O ports are compared on one 8-bit byte of the address. `IO_HIGH_HALF`=1 selects bits 15:8 and 0 selects bits 7:0. The other byte has no effect on I/O decoding.
- R5: A read strobe only ever drives read selects, and a write strobe only ever drives write selects. The read and write enables of one port therefore share an address and are told apart by the strobe.
- R6: Memory strobes never assert an I/O select, and I/O strobes never assert a memory select, even when the address would match a port of the other space.
- R7: When all four strobes are high, every select is 0.
- R8: When more than one strobe is low in the same cycle, every select is 0.
- R9: The selects present after a rising clock edge reflect the address and strobes sampled at that edge, so there is one cycle of latency.
- R10: For a configuration without overlaps, at most one select output is high in any cycle. An address matching two ports of one space is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Bus address |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| mem_rd_sel | output | MEM_PORTS | Per-memory-port read enable, bit i for port i |
| mem_wr_sel | output | MEM_PORTS | Per-memory-port write enable |
| io_rd_sel | output | IO_PORTS | Per-I/O-port read enable |
| io_wr_sel | output | IO_PORTS | Per-I/O-port write enable |

## Verification
The bench builds the block with three ports in each space.

- Memory ports: one absolute port at 0x2000, one partial port covering 0x8000..0x8FFF, and one partial port covering 0x4000..0x7FFF.
- I/O ports: one absolute port at 0x10, one partial port at 0x40..0x4F, and one partial port matching any port number with bit 7 set.
- I/O decoding uses the upper address byte.

With these values, a single run reaches single-address hits, aliasing across wide and narrow windows, and cross-space near misses, for example an I/O access whose upper byte equals a memory base. Because the I/O byte is the upper one, junk in the lower byte shows that the other byte is ignored. The configuration has no overlaps, so the overlap assertions stay quiet under random sweeps.

// File: rtl/bus_select_decoder.sv
module bus_select_decoder #(
  parameter int MEM_PORTS = 2,
  parameter int IO_PORTS  = 2,
  parameter logic [MEM_PORTS*16-1:0] MEM_BASE = {16'h8000, 16'h0000},
  parameter logic [MEM_PORTS*16-1:0] MEM_CARE = {16'hC000, 16'hFFFF},
  parameter logic [IO_PORTS*8-1:0]   IO_BASE  = {8'h20, 8'h00},
  parameter logic [IO_PORTS*8-1:0]   IO_CARE  = {8'hF0, 8'hFF},
  parameter bit IO_HIGH_HALF = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          addr,
  input  logic                 mem_rd_n,
  input  logic                 mem_wr_n,
  input  logic                 io_rd_n,
  input  logic                 io_wr_n,
  output logic [MEM_PORTS-1:0] mem_rd_sel,
  output logic [MEM_PORTS-1:0] mem_wr_sel,
  output logic [IO_PORTS-1:0]  io_rd_sel,
  output logic [IO_PORTS-1:0]  io_wr_sel
);
  localparam int AW = 16;
  localparam int PW = 8;

  logic [PW-1:0]        port_num;
  logic [MEM_PORTS-1:0] mem_hit;
  logic [IO_PORTS-1:0]  io_hit;
  logic [3:0]           strb;
  logic                 single;

  generate
    if (IO_HIGH_HALF) begin : g_hi
      assign port_num = addr[AW-1:AW-PW];
    end else begin : g_lo
      assign port_num = addr[PW-1:0];
    end
  endgenerate

  generate
    for (genvar i = 0; i < MEM_PORTS; i++) begin : g_mem
      assign mem_hit[i] = ((addr ^ MEM_BASE[i*AW +: AW]) & MEM_CARE[i*AW +: AW]) == '0;
    end
    for (genvar j = 0; j < IO_PORTS; j++) begin : g_io
      assign io_hit[j] = ((port_num ^ IO_BASE[j*PW +: PW]) & IO_CARE[j*PW +: PW]) == '0;
    end
  endgenerate

  assign strb   = ~{io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
  assign single = $onehot(strb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_sel <= '0;
      mem_wr_sel <= '0;
      io_rd_sel  <= '0;
      io_wr_sel  <= '0;
    end else begin
      mem_rd_sel <= mem_hit & {MEM_PORTS{single & strb[0]}};
      mem_wr_sel <= mem_hit & {MEM_PORTS{single & strb[1]}};
      io_rd_sel  <= io_hit  & {IO_PORTS{single & strb[2]}};
      io_wr_sel  <= io_hit  & {IO_PORTS{single & strb[3]}};
    end
  end
endmodule

module bus_select_decoder_chk #(
  parameter int MEM_PORTS = 2,
  parameter int IO_PORTS  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mem_rd_n,
  input logic                 mem_wr_n,
  input logic                 io_rd_n,
  input logic                 io_wr_n,
  input logic [MEM_PORTS-1:0] mem_hit,
  input logic [IO_PORTS-1:0]  io_hit,
  input logic [MEM_PORTS-1:0] mem_rd_sel,
  input logic [MEM_PORTS-1:0] mem_wr_sel,
  input logic [IO_PORTS-1:0]  io_rd_sel,
  input logic [IO_PORTS-1:0]  io_wr_sel
);
  logic [3:0] low;
  logic [2*MEM_PORTS+2*IO_PORTS-1:0] all_sel;
  assign low     = ~{io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
  assign all_sel = {io_wr_sel, io_rd_sel, mem_wr_sel, mem_rd_sel};

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> all_sel == '0);
  a_r10_mem_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mem_hit));
  a_r10_io_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(io_hit));
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(all_sel));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) low == 4'b0000 |=> all_sel == '0);
  a_r8_multi_quiet: assert property (@(posedge clk) disable iff (!rst_n) $countones(low) > 1 |=> all_sel == '0);
  a_r6_mem_space: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_n && mem_wr_n) |=> (mem_rd_sel == '0 && mem_wr_sel == '0));
  a_r6_io_space: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_n && io_wr_n) |=> (io_rd_sel == '0 && io_wr_sel == '0));
  a_r5_read_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_n && io_rd_n) |=> (mem_rd_sel == '0 && io_rd_sel == '0));
  a_r9_mem_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (low == 4'b0001) |=> mem_rd_sel == $past(mem_hit));
  a_r9_io_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (low == 4'b1000) |=> io_wr_sel == $past(io_hit));
endmodule

bind bus_select_decoder bus_select_decoder_chk #(.MEM_PORTS(MEM_PORTS), .IO_PORTS(IO_PORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .mem_hit(mem_hit), .io_hit(io_hit),
  .mem_rd_sel(mem_rd_sel), .mem_wr_sel(mem_wr_sel),
  .io_rd_sel(io_rd_sel), .io_wr_sel(io_wr_sel)
);

// File: tb/bus_select_decoder_tb_top.sv
`timescale 1ns/1ps
module bus_select_decoder_tb_top;
  localparam logic [15:0] MB0 = 16'h2000, MC0 = 16'hFFFF;
  localparam logic [15:0] MB1 = 16'h8000, MC1 = 16'hF000;
  localparam logic [15:0] MB2 = 16'h4000, MC2 = 16'hC000;
  localparam logic [7:0]  IB0 = 8'h10, IC0 = 8'hFF;
  localparam logic [7:0]  IB1 = 8'h40, IC1 = 8'hF0;
  localparam logic [7:0]  IB2 = 8'h80, IC2 = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [3:0] act = 4'b0000;
  logic [2:0] mrd, mwr, ird, iwr;
  logic [11:0] expv = '0;
  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  bus_select_decoder #(
    .MEM_PORTS(3), .IO_PORTS(3),
    .MEM_BASE({MB2, MB1, MB0}), .MEM_CARE({MC2, MC1, MC0}),
    .IO_BASE({IB2, IB1, IB0}), .IO_CARE({IC2, IC1, IC0}),
    .IO_HIGH_HALF(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .mem_rd_n(~act[0]), .mem_wr_n(~act[1]), .io_rd_n(~act[2]), .io_wr_n(~act[3]),
    .mem_rd_sel(mrd), .mem_wr_sel(mwr), .io_rd_sel(ird), .io_wr_sel(iwr)
  );

  function automatic logic [11:0] model(input logic [15:0] a, input logic [3:0] s);
    logic [2:0] mh, ih;
    int n;
    logic [11:0] r;
    mh[0] = (a & MC0) == (MB0 & MC0);
    mh[1] = (a & MC1) == (MB1 & MC1);
    mh[2] = (a & MC2) == (MB2 & MC2);
    ih[0] = (a[15:8] & IC0) == (IB0 & IC0);
    ih[1] = (a[15:8] & IC1) == (IB1 & IC1);
    ih[2] = (a[15:8] & IC2) == (IB2 & IC2);
    n = 0;
    for (int k = 0; k < 4; k++) if (s[k]) n++;
    r = '0;
    if (n == 1) begin
      if (s[0]) r[2:0]  = mh;
      if (s[1]) r[5:3]  = mwr_guard(mh);
      if (s[2]) r[8:6]  = ih;
      if (s[3]) r[11:9] = ih;
    end
    return r;
  endfunction

  function automatic logic [2:0] mwr_guard(input logic [2:0] v);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) expv <= '0;
    else expv <= model(addr, act);

  task automatic check(input string t, input logic [31:0] a, input logic [31:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual %h expected %h", t, a, e);
    end
  endtask

  always @(negedge clk) if (!done) check({tag, " model"}, {20'd0, iwr, ird, mwr, mrd}, {20'd0, expv});

  task automatic go(input logic [15:0] a, input logic [3:0] s, input string t);
    @(negedge clk);
    addr = a; act = s; tag = t;
    @(negedge clk);
  endtask

  logic [31:0] seed = 32'h1234_5678;

  initial begin
    addr = 16'h2000; act = 4'b0001;
    repeat (3) @(negedge clk);
    check("R1 reset", {20'd0, iwr, ird, mwr, mrd}, 32'd0);
    rst_n = 1'b1;
    act = 4'b0000;
    @(negedge clk);
    #1; addr = 16'h2000; act = 4'b0001; tag = "R9";
    #1 check("R9 before edge", {29'd0, mrd}, 32'd0);
    @(negedge clk);
    check("R9 after edge", {29'd0, mrd}, 32'd1);
    go(16'h2000, 4'b0001, "R2"); check("R2 absolute hit", {29'd0, mrd}, 32'd1);
    go(16'h2001, 4'b0001, "R2"); check("R2 absolute miss", {29'd0, mrd}, 32'd0);
    go(16'h8ABC, 4'b0001, "R3"); check("R3 alias mid", {29'd0, mrd}, 32'd2);
    go(16'h8FFF, 4'b0010, "R3"); check("R3 alias top write", {29'd0, mwr}, 32'd2);
    go(16'h9000, 4'b0001, "R3"); check("R3 alias miss", {29'd0, mrd}, 32'd0);
    go(16'h5A5A, 4'b0001, "R3"); check("R3 wide alias", {29'd0, mrd}, 32'd4);
    go(16'h4F33, 4'b0100, "R3"); check("R3 io alias", {29'd0, ird}, 32'd2);
    go(16'h1077, 4'b0100, "R4"); check("R4 high byte hit", {29'd0, ird}, 32'd1);
    go(16'h7710, 4'b0100, "R4"); check("R4 low byte ignored", {29'd0, ird}, 32'd0);
    go(16'hC0FF, 4'b1000, "R4"); check("R4 port bit7", {29'd0, iwr}, 32'd4);
    go(16'h1000, 4'b1000, "R5"); check("R5 write only", {26'd0, iwr, ird}, 32'h08);
    go(16'h1000, 4'b0100, "R5"); check("R5 read only", {26'd0, iwr, ird}, 32'h01);
    go(16'h2000, 4'b0100, "R6"); check("R6 io strobe at mem addr", {20'd0, iwr, ird, mwr, mrd}, 32'd0);
    go(16'h1010, 4'b0001, "R6"); check("R6 mem strobe at io port", {20'd0, iwr, ird, mwr, mrd}, 32'd0);
    go(16'h2000, 4'b0000, "R7"); check("R7 idle", {20'd0, iwr, ird, mwr, mrd}, 32'd0);
    go(16'h2000, 4'b0011, "R8"); check("R8 rd+wr", {20'd0, iwr, ird, mwr, mrd}, 32'd0);
    go(16'h1000, 4'b0101, "R8"); check("R8 mem+io", {20'd0, iwr, ird, mwr, mrd}, 32'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [3:0] s;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = seed[31:16];
      case (seed[3:2])
        2'd1: a = (seed[5]) ? (MB1 | (a & ~MC1)) : (MB2 | (a & ~MC2));
        2'd2: a = {(seed[6] ? IB1 : IB0) | (a[15:8] & ~(seed[6] ? IC1 : IC0)), a[7:0]};
        2'd3: a = seed[7] ? MB0 : {IB0, a[7:0]};
        default: ;
      endcase
      s = 4'b0001 << seed[9:8];
      if (seed[12:10] == 3'd0) s = 4'b0000;
      if (seed[12:10] == 3'd7) s = s | (4'b0001 << seed[14:13]);
      @(negedge clk);
      addr = a; act = s; tag = "R10 sweep";
    end
    @(negedge clk);
    act = 4'b0000;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule